// File: doc/BRIEF.md
# PWM Time-Base Counter with Synchronisation

This block is the timing core of one pulse-width-modulation channel. It divides the system clock with two cascaded dividers to make a counter tick. On each tick a 16-bit counter moves according to the selected mode: it counts up and wraps, counts down and reloads, counts up then down in a triangle, or holds. Downstream compare logic uses the counter value and its direction. The block raises single-cycle pulses when the counter sits at zero and when it sits at the active period.

The period can be written straight into the active register, or into a holding register that the block copies across at the next zero tick. The copy at zero keeps a period change from cutting a running cycle short.

Several identical units can be chained. A sync pulse, when phase loading is enabled, forces the counter to a programmed phase value. In triangle mode it also sets the direction of travel. Each unit drives a sync output that is taken from a selectable source and delayed by one register. The next unit's sync input can then start its cycle at a fixed offset.

Top module: `ptb_timebase`

## Requirements
- R1: After reset the counter is 0, the direction output is 1 (up), and evt_zero, evt_prd and sync_out are all low.
- R2: The counter tick fires once every H*L system clocks. H is 1 for hs_div code 0 and 2*code for codes 1 to 7 (1,2,4,...,14). L is 2 raised to ls_div (1 to 128).
- R3: Without a tick and without a sync load, the counter and the direction do not change.
- R4: In mode 0 (up), each tick advances the counter by one. A tick at or above the period gives 0, so the cycle is 0..P, which is P+1 ticks. The direction reads 1.
- R5: In mode 1 (down), each tick decrements the counter. A tick at 0 reloads the period, so the cycle is P..0. The direction reads 0.
- R6: In mode 2 (up-down), the counter rises from 0 to P and then falls back to 0, so one cycle is 2*P ticks. The direction reads 1 while the counter rises and 0 while it falls, and it flips on the tick that leaves P or 0. A period of 0 keeps the counter at 0.
- R7: In mode 3 (freeze), the counter holds its value and no event pulse is raised.
- R8: evt_zero is high for exactly one system clock, the tick cycle in which the counter equals 0. evt_prd is high in the tick cycle in which the counter equals the active period.
- R9: With prd_immediate=1, a write updates the active period at the same edge. With prd_immediate=0, a write goes to the holding register, and the active period takes that value at the next zero tick. A down-mode reload at that zero tick uses the new value.
- R10: A sync_in pulse with phase_en=1 loads phase_val into the counter on the next edge. This happens in every mode, including freeze, and takes priority over the tick. With phase_en=0, sync_in does not change the counter.
- R11: On a sync load in mode 2, the direction becomes phase_up (0 = down, 1 = up). In mode 0 the direction becomes 1 and in mode 1 it becomes 0, whatever phase_up is.
- R12: sync_out is registered one clock after its source. sync_sel 0 selects sync_in, 1 selects evt_zero, 2 selects cmpb_hit, and 3 keeps sync_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up-down, 3 freeze |
| hs_div | input | 3 | First divider code (1,2,4..14) |
| ls_div | input | 3 | Second divider code (power of two, 1..128) |
| prd_immediate | input | 1 | 1: period writes go straight to the active register |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write value |
| phase_en | input | 1 | Enables loading the phase value on sync |
| phase_val | input | 16 | Value loaded into the counter on sync |
| phase_up | input | 1 | Direction after sync in up-down mode |
| sync_sel | input | 2 | sync_out source select |
| cmpb_hit | input | 1 | Compare-B match strobe from compare logic |
| sync_in | input | 1 | Sync pulse from the previous unit |
| tb_cnt | output | 16 | Counter value |
| tb_dir_up | output | 1 | Count direction, 1 = up |
| evt_zero | output | 1 | Counter-at-zero tick pulse |
| evt_prd | output | 1 | Counter-at-period tick pulse |
| sync_out | output | 1 | Sync pulse to the next unit |

## Verification
The bench sweeps all 64 divider code pairs and measures the spacing between counter steps. A wrong divider lookup or an off-by-one terminal count shows up directly as a spacing error. It runs the up, down and triangle modes over several short periods and compares every step with the expected ramp. A design that turns around one tick late, or that loses the 0..P wrap, fails on the first period. Period changes are made mid-cycle, both in shadow and in immediate mode. A design that copies the holding register early cuts the running cycle short, and one that reloads the down counter with the stale period shows the old value after zero. Sync loads are tried in freeze, with phase loading disabled, and with both settings of the post-sync direction. A design that honours the direction bit outside triangle mode, or that blocks loads while frozen, shows a wrong next count.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_HOLD = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_OFF  = 2'd3
  } sync_src_e;

  // First-stage divisor: code 0 gives 1, otherwise twice the code.
  function automatic int unsigned hs_factor(int unsigned code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  // Combined divisor of both stages.
  function automatic int unsigned prescale_div(int unsigned hs, int unsigned ls);
    return hs_factor(hs) << ls;
  endfunction

endpackage

// File: rtl/ptb_prescale.sv
module ptb_prescale #(
  parameter int HS_W = 3,
  parameter int LS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HS_W-1:0] hs_code,
  input  logic [LS_W-1:0] ls_code,
  output logic            tick
);
  import ptb_pkg::*;

  localparam int MAX_DIV = prescale_div(2**HS_W - 1, 2**LS_W - 1);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_val;

  assign div_val = DIV_W'(prescale_div(32'(hs_code), 32'(ls_code)));
  // ">=" lets a divider shrink mid-count recover within one cycle
  assign tick    = (pre_cnt >= div_val - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;
  end

  // R2: a tick is never followed directly by another unless the divisor is 1
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val > 1) |=> (!tick || div_val == 1));

endmodule

// File: rtl/ptb_period.sv
module ptb_period #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_PRD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             immediate,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             zero_tick,
  output logic [CNT_W-1:0] active,
  output logic [CNT_W-1:0] eff
);
  logic [CNT_W-1:0] shadow;
  logic             xfer;

  assign xfer = zero_tick && !immediate;
  // value the counter should use this cycle, including a transfer at zero
  assign eff  = xfer ? shadow : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_PRD;
      active <= RST_PRD;
    end else begin
      if (wr) shadow <= wdata;
      if (wr && immediate) active <= wdata;
      else if (xfer)       active <= shadow;
    end
  end

  // R9: in shadow mode the active period only moves on a zero tick
  a_r9_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!immediate && !zero_tick) |=> $stable(active));

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ptb_pkg::cnt_mode_e mode,
  input  logic               tick,
  input  logic [CNT_W-1:0]   prd,
  input  logic               sync_load,
  input  logic [CNT_W-1:0]   phase,
  input  logic               phase_up,
  output logic [CNT_W-1:0]   cnt,
  output logic               dir_up
);
  import ptb_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_dir;

  always_comb begin
    nxt_cnt = cnt;
    nxt_dir = dir_up;
    if (sync_load) begin
      nxt_cnt = phase;
      case (mode)
        MODE_UP:   nxt_dir = 1'b1;
        MODE_DOWN: nxt_dir = 1'b0;
        MODE_UPDN: nxt_dir = phase_up;
        default:   nxt_dir = dir_up;
      endcase
    end else if (tick) begin
      case (mode)
        MODE_UP: begin
          nxt_dir = 1'b1;
          nxt_cnt = (cnt >= prd) ? '0 : cnt + ONE;
        end
        MODE_DOWN: begin
          nxt_dir = 1'b0;
          nxt_cnt = (cnt == '0 || cnt > prd) ? prd : cnt - ONE;
        end
        MODE_UPDN: begin
          if (prd == '0) begin
            nxt_cnt = '0;
          end else if (dir_up) begin
            if (cnt >= prd) begin
              nxt_dir = 1'b0;
              nxt_cnt = prd - ONE;
            end else begin
              nxt_cnt = cnt + ONE;
            end
          end else begin
            if (cnt == '0) begin
              nxt_dir = 1'b1;
              nxt_cnt = ONE;
            end else begin
              nxt_cnt = cnt - ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      cnt    <= nxt_cnt;
      dir_up <= nxt_dir;
    end
  end

  // R3: between prescaler ticks the counter stands still
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync_load) |=> ($stable(cnt) && $stable(dir_up)));

  // R4: up mode below the period steps by one
  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_load && mode == MODE_UP && cnt < prd) |=> (cnt == $past(cnt) + ONE));

  // R6: triangle turns around when leaving the period
  a_r6_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync_load && mode == MODE_UPDN && dir_up && prd != '0 && cnt == prd) |=> !dir_up);

  // R10: a sync load lands the phase value
  a_r10_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load |=> (cnt == $past(phase)));

  // R11: post-sync direction in triangle mode
  a_r11_post_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_load && mode == MODE_UPDN) |=> (dir_up == $past(phase_up)));

endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase #(
  parameter int CNT_W = 16,
  parameter int HS_W  = 3,
  parameter int LS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cnt_mode,
  input  logic [HS_W-1:0]  hs_div,
  input  logic [LS_W-1:0]  ls_div,
  input  logic             prd_immediate,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_wdata,
  input  logic             phase_en,
  input  logic [CNT_W-1:0] phase_val,
  input  logic             phase_up,
  input  logic [1:0]       sync_sel,
  input  logic             cmpb_hit,
  input  logic             sync_in,
  output logic [CNT_W-1:0] tb_cnt,
  output logic             tb_dir_up,
  output logic             evt_zero,
  output logic             evt_prd,
  output logic             sync_out
);
  import ptb_pkg::*;

  cnt_mode_e        mode;
  sync_src_e        so_sel;
  logic             tick;
  logic             sync_load;
  logic             running;
  logic             zero_tick;
  logic [CNT_W-1:0] prd_active;
  logic [CNT_W-1:0] prd_eff;
  logic             so_src;

  assign mode      = cnt_mode_e'(cnt_mode);
  assign so_sel    = sync_src_e'(sync_sel);
  assign sync_load = sync_in && phase_en;
  assign running   = (mode != MODE_HOLD);
  assign zero_tick = tick && running && (tb_cnt == '0);

  ptb_prescale #(.HS_W(HS_W), .LS_W(LS_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_code (hs_div),
    .ls_code (ls_div),
    .tick    (tick)
  );

  ptb_period #(.CNT_W(CNT_W)) u_prd (
    .clk       (clk),
    .rst_n     (rst_n),
    .immediate (prd_immediate),
    .wr        (prd_wr),
    .wdata     (prd_wdata),
    .zero_tick (zero_tick),
    .active    (prd_active),
    .eff       (prd_eff)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .tick      (tick),
    .prd       (prd_eff),
    .sync_load (sync_load),
    .phase     (phase_val),
    .phase_up  (phase_up),
    .cnt       (tb_cnt),
    .dir_up    (tb_dir_up)
  );

  assign evt_zero = zero_tick;
  assign evt_prd  = tick && running && (tb_cnt == prd_active);

  always_comb begin
    case (so_sel)
      SO_PASS: so_src = sync_in;
      SO_ZERO: so_src = evt_zero;
      SO_CMPB: so_src = cmpb_hit;
      default: so_src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= so_src;
  end

  // R12: a disabled sync-out select yields no pulse
  a_r12_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sync_sel) == 2'd3) |-> !sync_out);

  // R7: frozen counter raises no event
  a_r7_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'd3) |-> (!evt_zero && !evt_prd));

endmodule

// File: tb/ptb_timebase_test.sv
`timescale 1ns/1ps
module ptb_timebase_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cnt_mode = 2'd3;
  logic [2:0]  hs_div = '0;
  logic [2:0]  ls_div = '0;
  logic        prd_immediate = 1'b1;
  logic        prd_wr = 1'b0;
  logic [15:0] prd_wdata = '0;
  logic        phase_en = 1'b0;
  logic [15:0] phase_val = '0;
  logic        phase_up = 1'b0;
  logic [1:0]  sync_sel = 2'd3;
  logic        cmpb_hit = 1'b0;
  logic        sync_in = 1'b0;
  logic [15:0] tb_cnt;
  logic        tb_dir_up, evt_zero, evt_prd, sync_out;

  int total = 0;
  int bad = 0;
  int seq[$];

  always #10 clk = ~clk;

  ptb_timebase uut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .hs_div(hs_div), .ls_div(ls_div),
    .prd_immediate(prd_immediate), .prd_wr(prd_wr), .prd_wdata(prd_wdata),
    .phase_en(phase_en), .phase_val(phase_val), .phase_up(phase_up),
    .sync_sel(sync_sel), .cmpb_hit(cmpb_hit), .sync_in(sync_in),
    .tb_cnt(tb_cnt), .tb_dir_up(tb_dir_up), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .sync_out(sync_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_prd(input int p);
    prd_immediate = 1'b1; prd_wr = 1'b1; prd_wdata = 16'(p);
    @(negedge clk);
    prd_wr = 1'b0;
  endtask

  task automatic load(input logic [1:0] m, input int ph, input bit d);
    cnt_mode = m; phase_val = 16'(ph); phase_up = d; phase_en = 1'b1; sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic run_seq(input string req);
    foreach (seq[i]) begin
      check(tb_cnt == 16'(seq[i]), req, int'(tb_cnt), seq[i]);
      @(negedge clk);
    end
  endtask

  task automatic measure(input int expn, input string req);
    int n;
    logic [15:0] prev;
    prev = tb_cnt; n = 0;
    while (tb_cnt == prev && n < 5000) begin @(negedge clk); n++; end
    for (int r = 0; r < 2; r++) begin
      prev = tb_cnt; n = 0;
      do begin @(negedge clk); n++; end while (tb_cnt == prev && n < 5000);
      check(n == expn, req, n, expn);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tb_cnt == 0, "R1 cnt", int'(tb_cnt), 0);
    check(tb_dir_up == 1'b1, "R1 dir", int'(tb_dir_up), 1);
    check(!evt_zero && !evt_prd, "R1 events", int'({evt_zero, evt_prd}), 0);
    check(sync_out == 1'b0, "R1 sync_out", int'(sync_out), 0);

    // R4 / R8 up mode sweep over periods
    for (int p = 0; p <= 4; p++) begin
      cnt_mode = 2'd3;
      set_prd(p);
      load(2'd0, 0, 1'b0);
      for (int k = 0; k < 2 * p + 4; k++) begin
        int e;
        e = k % (p + 1);
        check(tb_cnt == 16'(e), "R4 up count", int'(tb_cnt), e);
        check(evt_zero == (e == 0), "R8 zero pulse", int'(evt_zero), int'(e == 0));
        check(evt_prd == (e == p), "R8 period pulse", int'(evt_prd), int'(e == p));
        check(tb_dir_up == 1'b1, "R4 dir", int'(tb_dir_up), 1);
        @(negedge clk);
      end
    end

    // R5 down mode sweep
    for (int p = 1; p <= 4; p++) begin
      cnt_mode = 2'd3;
      set_prd(p);
      load(2'd1, p, 1'b1);
      for (int k = 0; k < 2 * p + 4; k++) begin
        int e;
        e = p - (k % (p + 1));
        check(tb_cnt == 16'(e), "R5 down count", int'(tb_cnt), e);
        check(tb_dir_up == 1'b0, "R5 dir", int'(tb_dir_up), 0);
        @(negedge clk);
      end
    end

    // R6 up-down triangle
    for (int p = 1; p <= 4; p++) begin
      cnt_mode = 2'd3;
      set_prd(p);
      load(2'd2, 0, 1'b1);
      for (int k = 0; k < 4 * p + 1; k++) begin
        int m, e, d;
        m = k % (2 * p);
        e = (m <= p) ? m : 2 * p - m;
        d = (k == 0) ? 1 : ((m >= 1 && m <= p) ? 1 : 0);
        check(tb_cnt == 16'(e), "R6 triangle count", int'(tb_cnt), e);
        check(tb_dir_up == d[0], "R6 dir", int'(tb_dir_up), d);
        @(negedge clk);
      end
    end

    // R11 post-sync direction
    cnt_mode = 2'd3;
    set_prd(5);
    load(2'd2, 2, 1'b0);
    seq = '{2, 1, 0, 1, 2}; run_seq("R11 updn dir=0");
    load(2'd2, 2, 1'b1);
    seq = '{2, 3, 4, 5, 4}; run_seq("R11 updn dir=1");
    load(2'd0, 2, 1'b0);
    check(tb_dir_up == 1'b1, "R11 up ignores bit", int'(tb_dir_up), 1);
    seq = '{2, 3, 4}; run_seq("R11 up mode");
    load(2'd1, 2, 1'b1);
    check(tb_dir_up == 1'b0, "R11 down ignores bit", int'(tb_dir_up), 0);
    seq = '{2, 1, 0}; run_seq("R11 down mode");

    // R10 sync ignored when phase loading disabled
    set_prd(9);
    load(2'd0, 0, 1'b0);
    @(negedge clk); @(negedge clk);
    phase_en = 1'b0; phase_val = 16'd7; sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check(tb_cnt == 16'd3, "R10 sync disabled", int'(tb_cnt), 3);
    @(negedge clk);
    check(tb_cnt == 16'd4, "R10 sync disabled next", int'(tb_cnt), 4);

    // R10 / R7 load while frozen, then hold
    load(2'd3, 7, 1'b0);
    for (int k = 0; k < 4; k++) begin
      check(tb_cnt == 16'd7, "R7 frozen hold (R10 load)", int'(tb_cnt), 7);
      check(!evt_zero && !evt_prd, "R7 no events", int'({evt_zero, evt_prd}), 0);
      @(negedge clk);
    end

    // R9 shadow write in up mode takes effect after zero
    set_prd(3);
    load(2'd0, 0, 1'b0);
    @(negedge clk);
    prd_immediate = 1'b0; prd_wr = 1'b1; prd_wdata = 16'd6;
    @(negedge clk);
    prd_wr = 1'b0;
    seq = '{2, 3, 0, 1, 2, 3, 4, 5, 6, 0}; run_seq("R9 shadow up");

    // R9 immediate shrink
    set_prd(6);
    load(2'd0, 5, 1'b0);
    prd_immediate = 1'b1; prd_wr = 1'b1; prd_wdata = 16'd2;
    @(negedge clk);
    prd_wr = 1'b0;
    seq = '{6, 0, 1}; run_seq("R9 immediate");
    check(tb_cnt == 16'd2 && evt_prd, "R9 new period event", int'(evt_prd), 1);
    @(negedge clk);
    check(tb_cnt == 16'd0, "R9 wrap at new period", int'(tb_cnt), 0);

    // R9 shadow write in down mode: reload uses new period
    cnt_mode = 2'd3;
    set_prd(3);
    load(2'd1, 3, 1'b0);
    prd_immediate = 1'b0; prd_wr = 1'b1; prd_wdata = 16'd5;
    @(negedge clk);
    prd_wr = 1'b0;
    seq = '{2, 1, 0, 5, 4}; run_seq("R9 shadow down");

    // R12 sync-out sources
    cnt_mode = 2'd3; phase_en = 1'b0;
    sync_sel = 2'd0; sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check(sync_out == 1'b1, "R12 pass-through", int'(sync_out), 1);
    @(negedge clk);
    check(sync_out == 1'b0, "R12 pass-through single", int'(sync_out), 0);
    sync_sel = 2'd2; cmpb_hit = 1'b1;
    @(negedge clk);
    cmpb_hit = 1'b0;
    check(sync_out == 1'b1, "R12 compare-B", int'(sync_out), 1);
    @(negedge clk);
    check(sync_out == 1'b0, "R12 compare-B single", int'(sync_out), 0);
    sync_sel = 2'd3; cmpb_hit = 1'b1; sync_in = 1'b1;
    @(negedge clk);
    cmpb_hit = 1'b0; sync_in = 1'b0;
    check(sync_out == 1'b0, "R12 disabled", int'(sync_out), 0);
    @(negedge clk);
    check(sync_out == 1'b0, "R12 disabled next", int'(sync_out), 0);
    sync_sel = 2'd1;
    set_prd(2);
    load(2'd0, 0, 1'b0);
    begin
      logic prev_zero;
      prev_zero = evt_zero;
      @(negedge clk);
      for (int k = 0; k < 9; k++) begin
        check(sync_out == prev_zero, "R12 zero source", int'(sync_out), int'(prev_zero));
        prev_zero = evt_zero;
        @(negedge clk);
      end
    end
    sync_sel = 2'd3;

    // R8 event width with a divider of 4
    hs_div = 3'd1; ls_div = 3'd1;
    set_prd(2);
    load(2'd0, 0, 1'b0);
    begin
      int nz, np;
      nz = 0; np = 0;
      for (int k = 0; k < 36; k++) begin
        if (evt_zero) nz++;
        if (evt_prd) np++;
        @(negedge clk);
      end
      check(nz == 3, "R8 zero pulse count", nz, 3);
      check(np == 3, "R8 period pulse count", np, 3);
    end

    // R2 / R3 full divider sweep
    set_prd(16'hFFFF);
    load(2'd0, 0, 1'b0);
    for (int h = 0; h < 8; h++) begin
      for (int l = 0; l < 8; l++) begin
        int f;
        f = (h == 0) ? 1 : h + h;
        hs_div = 3'(h); ls_div = 3'(l);
        measure(f * (1 << l), "R2 tick spacing (R3)");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule